// File: doc/BRIEF.md
# Two-Stage Ramped Frequency Phase Generator

This block produces the phase word for a direct digital synthesizer. A 48-bit phase accumulator adds a frequency tuning word on every system clock. The upper phase bits leave the block for a sine lookup, which is outside this block.

The tuning word depends on the operating mode. In single-tone mode it is a fixed programmed frequency. In chirp mode and ramped-FSK mode it is a base frequency plus a second 48-bit accumulator. That ramp accumulator adds a programmed delta word each time a programmable 20-bit rate divider expires, so the output frequency climbs or falls in steps at a slower rate of its own. In ramped-FSK mode a select pin chooses one of two base frequencies, and each change of that pin restarts the ramp.

Software writes settings one at a time into holding registers. A single update strobe then moves all of them into the working set at the same clock edge. The reset input is filtered: only a pulse of at least ten cycles reinitializes the block.

Top module: `ramp_fsk_synth`

## Requirements
- R1: On every clock the 48-bit phase state adds the tuning word modulo 2^48. `phase_o` shows its upper 17 bits (bits 47..31).
- R2: In single-tone mode (mode code 0) the tuning word is the active F1 register. The delta and rate settings have no effect on the output.
- R3: In a ramp mode, a down-counter loaded with rate value R expires once every R+1 clocks. On each expiry the ramp accumulator adds the active delta word, modulo 2^48. A negative delta in two's complement makes the frequency fall.
- R4: In a ramp mode the tuning word is base + ramp accumulator. Chirp (mode code 2) always uses F1 as the base. Ramped-FSK (mode code 1) uses F2 when the registered `fsk_sel` is 1 and F1 when it is 0.
- R5: `wr_en` with `wr_sel` writes only a holding register. Selector codes are: 0 F1, 1 F2, 2 delta, 3 rate (low 20 bits), 4 mode (low 2 bits). Nothing reaches the output until a cycle with `upd` high copies all holding registers into the active set.
- R6: The ramp accumulator returns to zero, and the rate counter reloads, in two cases: when an update changes the mode code, and in ramped-FSK mode at each change of `fsk_sel`. Each ramp therefore starts from its base frequency.
- R7: A reset pulse held for at least 10 clocks sets every register to zero, which gives single-tone mode, F1 = 0 and phase 0. A pulse of 9 clocks or fewer has no effect.
- R8: Mode code 3 behaves as single-tone mode. Writes with selector codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset request, filtered for length |
| wr_en | input | 1 | Write strobe for a holding register |
| wr_sel | input | 3 | Holding register selector |
| wr_data | input | 48 | Write data |
| upd | input | 1 | Copies all holding registers to the active set |
| fsk_sel | input | 1 | Base frequency choice in ramped-FSK mode |
| phase_o | output | 17 | Upper bits of the phase state |

## Verification
Single-tone runs use a small F1 and a large F1. The large value separates correct modulo-2^48 wrapping from saturation or a lost carry. Chirp runs sweep the rate from 0 to 3 with a rising and a falling delta, which exposes off-by-one errors in the divider period and sign mistakes in the ramp addition. Ramped-FSK runs toggle the select pin in the middle of a ramp, which shows whether the base switches and whether the ramp restarts. The same toggle in chirp mode must do nothing. Reset pulses of 5 and 10 cycles show that the length filter sits at exactly ten clocks.

// File: rtl/ramp_fsk_synth.sv
module ramp_fsk_synth #(
  parameter int PHASE_W = 48,
  parameter int RATE_W  = 20,
  parameter int OUT_W   = 17,
  parameter int RST_MIN = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               upd,
  input  logic               fsk_sel,
  output logic [OUT_W-1:0]   phase_o
);
  localparam int RC_W = $clog2(RST_MIN + 1);
  localparam logic [1:0] M_FSK   = 2'd1;
  localparam logic [1:0] M_CHIRP = 2'd2;

  logic [RC_W-1:0]    rst_cnt;
  logic               hold;

  logic [PHASE_W-1:0] b_f1, b_f2, b_del;
  logic [RATE_W-1:0]  b_rate;
  logic [1:0]         b_mode;
  logic [PHASE_W-1:0] a_f1, a_f2, a_del;
  logic [RATE_W-1:0]  a_rate;
  logic [1:0]         a_mode;

  logic [PHASE_W-1:0] facc, pacc, base, ftw;
  logic [RATE_W-1:0]  rcnt, rate_nx;
  logic               fsk_q, ramp, restart;

  assign hold = rst && (rst_cnt == RC_W'(RST_MIN - 1));

  always_ff @(posedge clk) begin
    if (!rst)      rst_cnt <= '0;
    else if (!hold) rst_cnt <= rst_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      b_f1 <= '0; b_f2 <= '0; b_del <= '0; b_rate <= '0; b_mode <= '0;
      a_f1 <= '0; a_f2 <= '0; a_del <= '0; a_rate <= '0; a_mode <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          3'd0: b_f1   <= wr_data;
          3'd1: b_f2   <= wr_data;
          3'd2: b_del  <= wr_data;
          3'd3: b_rate <= wr_data[RATE_W-1:0];
          3'd4: b_mode <= wr_data[1:0];
          default: ;
        endcase
      end
      if (upd) begin
        a_f1 <= b_f1; a_f2 <= b_f2; a_del <= b_del;
        a_rate <= b_rate; a_mode <= b_mode;
      end
    end
  end

  assign ramp    = (a_mode == M_FSK) || (a_mode == M_CHIRP);
  assign restart = (upd && (b_mode != a_mode)) ||
                   ((a_mode == M_FSK) && (fsk_sel != fsk_q));
  assign rate_nx = upd ? b_rate : a_rate;
  assign base    = ((a_mode == M_FSK) && fsk_q) ? a_f2 : a_f1;
  assign ftw     = base + facc;
  assign phase_o = pacc[PHASE_W-1 -: OUT_W];

  always_ff @(posedge clk) begin
    if (hold) begin
      facc  <= '0;
      rcnt  <= '0;
      fsk_q <= 1'b0;
      pacc  <= '0;
    end else begin
      fsk_q <= fsk_sel;
      pacc  <= pacc + ftw;
      if (restart || !ramp) begin
        facc <= '0;
        rcnt <= rate_nx;
      end else if (rcnt == '0) begin
        facc <= facc + a_del;
        rcnt <= a_rate;
      end else begin
        rcnt <= rcnt - 1'b1;
      end
    end
  end
endmodule

module ramp_fsk_synth_chk #(
  parameter int PHASE_W = 48
) (
  input logic               clk,
  input logic               rst,
  input logic               hold,
  input logic               upd,
  input logic               fsk_sel,
  input logic               fsk_q,
  input logic [1:0]         a_mode,
  input logic [PHASE_W-1:0] a_f1,
  input logic [PHASE_W-1:0] a_f2,
  input logic [PHASE_W-1:0] a_del,
  input logic [PHASE_W-1:0] facc,
  input logic [PHASE_W-1:0] pacc
);
  bit seen = 1'b0;
  always_ff @(posedge clk) if (hold) seen <= 1'b1;

  // R2
  tone_flat_chk: assert property (@(posedge clk) disable iff (!seen || rst)
    (a_mode == 2'd0) |-> (facc == '0));

  // R3
  ramp_step_chk: assert property (@(posedge clk) disable iff (!seen || rst)
    (facc != $past(facc)) |-> ((facc == PHASE_W'($past(facc) + $past(a_del))) || (facc == '0)));

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!seen || rst)
    (!upd && !hold) |=> ($stable(a_f1) && $stable(a_f2) && $stable(a_del) && $stable(a_mode)));

  // R6
  fsk_clear_chk: assert property (@(posedge clk) disable iff (!seen || rst)
    ((a_mode == 2'd1) && (fsk_sel != fsk_q)) |=> (facc == '0));

  // R7
  reset_default_chk: assert property (@(posedge clk) disable iff (!seen)
    hold |=> ((pacc == '0) && (facc == '0) && (a_mode == 2'd0)));
endmodule

bind ramp_fsk_synth ramp_fsk_synth_chk #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/test_ramp_fsk_synth.sv
module test_ramp_fsk_synth;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b0, wr_en = 1'b0, upd = 1'b0, fsk_sel = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [47:0] wr_data = '0;
  logic [16:0] phase_o;

  always #(CLK_P/2) clk = ~clk;

  ramp_fsk_synth i_ramp_fsk_synth (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd(upd), .fsk_sel(fsk_sel), .phase_o(phase_o));

  int total = 0, bad = 0;
  bit done = 1'b0, chk_en = 1'b0;
  string tag = "R7";

  logic [47:0] mb [5];
  logic [47:0] ma [5];
  logic        m_fq = 1'b0;
  longint unsigned m_k = 0;
  logic [47:0] m_p = '0;
  int          m_rc = 0;

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic        hold_m, ramp_m, clr;
    logic [47:0] base, fa, p_n;
    logic [47:0] nb [5];
    logic [47:0] na [5];
    longint unsigned k_n;
    int          rc_n;
    if (chk_en) check(tag, {31'd0, phase_o}, {31'd0, m_p[47:31]});
    hold_m = rst && (m_rc >= 9);
    rc_n = rst ? ((m_rc < 9) ? m_rc + 1 : m_rc) : 0;
    nb = mb; na = ma;
    if (hold_m) begin
      for (int i = 0; i < 5; i++) begin nb[i] = '0; na[i] = '0; end
      p_n = '0; k_n = 0;
    end else begin
      ramp_m = (ma[4][1:0] == 2'd1) || (ma[4][1:0] == 2'd2);
      base = ((ma[4][1:0] == 2'd1) && m_fq) ? ma[1] : ma[0];
      fa = ramp_m ? 48'((m_k / (longint'(ma[3]) + 1)) * longint'(ma[2])) : 48'd0;
      p_n = m_p + base + fa;
      clr = (upd && (mb[4][1:0] != ma[4][1:0])) ||
            ((ma[4][1:0] == 2'd1) && (fsk_sel != m_fq));
      k_n = clr ? 0 : m_k + 1;
      if (upd) na = mb;
      if (wr_en && wr_sel < 3'd5)
        nb[wr_sel] = (wr_sel == 3'd3) ? {28'd0, wr_data[19:0]} :
                     (wr_sel == 3'd4) ? {46'd0, wr_data[1:0]} : wr_data;
    end
    @(posedge clk);
    mb = nb; ma = na; m_p = p_n; m_k = k_n; m_rc = rc_n;
    m_fq = hold_m ? 1'b0 : fsk_sel;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [2:0] s, logic [47:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic update();
    upd = 1'b1; step(); upd = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin mb[i] = '0; ma[i] = '0; end
    @(negedge clk);
    run(2);
    rst = 1'b1; run(12); rst = 1'b0;
    chk_en = 1'b1;
    tag = "R7"; run(5);
    check("R7", {31'd0, phase_o}, 48'd0);

    tag = "R2";
    wr(3'd0, 48'h0012_3456_789A); wr(3'd2, 48'h0001_0000_0000); wr(3'd3, 48'd1);
    update(); run(40);

    tag = "R8"; wr(3'd5, 48'hFFFF_FFFF_FFFF); wr(3'd7, 48'h1234); run(10);
    wr(3'd4, 48'd3); update(); run(20);
    wr(3'd4, 48'd0); update();

    tag = "R1"; wr(3'd0, 48'h9000_0000_0001); update(); run(30);

    tag = "R5"; wr(3'd0, 48'h0000_0000_0100); run(20);
    update(); run(10);

    tag = "R3";
    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < 2; j++) begin
        wr(3'd4, 48'd0); update();
        wr(3'd0, 48'h0010_0000_0000);
        wr(3'd2, (j == 0) ? 48'h0000_4000_0000 : 48'hFFF0_0000_0000);
        wr(3'd3, 48'(r));
        wr(3'd4, 48'd2); update(); run(40);
      end
    end

    tag = "R4"; wr(3'd1, 48'h0300_0000_0000); fsk_sel = 1'b1; run(15); fsk_sel = 1'b0; run(15);

    tag = "R6";
    wr(3'd4, 48'd0); update();
    wr(3'd0, 48'h0010_0000_0000); wr(3'd1, 48'h0030_0000_0000);
    wr(3'd2, 48'h0000_1000_0000); wr(3'd3, 48'd2); wr(3'd4, 48'd1); update();
    run(25); fsk_sel = 1'b1; run(25); fsk_sel = 1'b0; run(25);

    tag = "R7";
    rst = 1'b1; run(5); rst = 1'b0; run(10);
    rst = 1'b1; run(10); rst = 1'b0; run(10);
    check("R7", {31'd0, phase_o}, 48'd0);
    finish_up();
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      finish_up();
    end
  end
endmodule